// File: doc/BRIEF.md
# Trigger Acceptance and Deadtime Controller

This block stands between a trigger source and an analog-to-digital converter. A rising edge on the trigger input starts a conversion only when the acquisition chain is idle. Once a conversion has started, the chain reports busy and every further edge is dropped. A conversion result is not passed straight on. It goes into a small derandomizer queue, and downstream processing drains that queue over a valid/ready stream. This decouples the rate at which samples are produced from the rate at which they are used.

The busy signal stays high while a conversion is in flight. It also stays high while the queue holds its full parameterised number of entries. With a depth of one, this gives the classic unbuffered behaviour: the chain stays blocked for the conversion time plus the time processing needs to take the sample. The block also keeps two saturating cycle accumulators, one for all cycles and one for busy cycles. A strobe captures both into output registers and restarts them from zero. Deadtime is the ratio of the captured busy count to the captured total, and efficiency is one minus that ratio.

The output stream follows normal back-pressure rules. A word leaves the queue only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the word on `out_data` and the valid flag are held unchanged. `out_ready` may be held low for any length of time. The converter side cannot be back-pressured. Instead, no conversion is started unless the queue has room for its result.

Top module: `trig_busy_ctrl`

## Requirements
- R1: A conversion start (`adc_start`) is a single-cycle pulse. It is raised in the cycle after `trig_in` is seen to change from 0 to 1 while `busy` is 0. No other condition raises it.
- R2: A trigger rising edge seen while `busy` is 1 is discarded. It never produces a start, either then or later.
- R3: `busy` rises together with `adc_start`. The conversion phase ends in the cycle after `adc_done` is seen during a conversion. `adc_done` outside a conversion has no effect.
- R4: `busy` equals "conversion in flight" OR "queue holds DEPTH entries". With DEPTH = 1, this keeps `busy` high from the start until processing has taken the sample.
- R5: The value on `adc_data` in the cycle of an accepted `adc_done` is queued. `out_valid` is 1 exactly when the queue is non-empty. `out_data` always shows the oldest entry, so words leave in arrival order.
- R6: A word is removed only in a cycle with `out_valid` and `out_ready` both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change in the next cycle.
- R7: The queue is never written while it holds DEPTH entries, so no sample is lost or overwritten.
- R8: Every clock cycle out of reset adds one to the total accumulator. Every such cycle with `busy` = 1 adds one to the busy accumulator. When `snap_req` is 1, `snap_total` and `snap_busy` load the counts including that cycle, and both accumulators restart from zero.
- R9: Both accumulators saturate at 2^CNT_W - 1 rather than wrapping. A captured busy count never exceeds the captured total.
- R10: After reset, `adc_start`, `busy` and `out_valid` are 0, and both snapshot outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Trigger level; its rising edge requests a conversion |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | Converter reports the result on adc_data |
| adc_data | input | DATA_W | Conversion result |
| busy | output | 1 | Chain cannot accept a trigger |
| out_valid | output | 1 | Queue holds a word for processing |
| out_ready | input | 1 | Processing takes the word this cycle |
| out_data | output | DATA_W | Oldest queued word |
| snap_req | input | 1 | Capture the accumulators and restart them |
| snap_total | output | CNT_W | Captured total cycle count |
| snap_busy | output | CNT_W | Captured busy cycle count |

## Verification
Two kinds of events are made to land in the same cycle. The first is a trigger edge arriving in the very cycle that `adc_done` closes a conversion. That edge must be dropped, because `busy` only falls one cycle later. The second is a capture strobe falling on a busy cycle. The captured busy count must include that cycle, and the accumulator must still restart from zero. Both situations come up many times in a sweep of trigger rates against drain rates. That sweep runs on a three-deep and a one-deep instance driven by the same inputs. A cycle-level reference model in the bench predicts every start, the busy level, the queue contents and both captures. A long window with no capture drives the narrow accumulators into saturation.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;
  // conversion phase of the acquisition chain
  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_RUN  = 1'b1
  } conv_st_t;
endpackage

// File: rtl/trig_gate.sv
module trig_gate
  import trig_busy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic adc_done,
  input  logic hold,       // queue full
  output logic adc_start,
  output logic busy,
  output logic result_wr   // conversion finished, store its result
);
  logic     trig_q;
  logic     start_q;
  conv_st_t st;
  logic     edge_seen;
  logic     accept;

  assign busy      = (st == CONV_RUN) | hold;
  assign edge_seen = trig_in & ~trig_q;
  assign accept    = edge_seen & ~busy;
  assign result_wr = (st == CONV_RUN) & adc_done;
  assign adc_start = start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      start_q <= 1'b0;
      st      <= CONV_IDLE;
    end else begin
      trig_q  <= trig_in;
      start_q <= accept;
      if (accept)         st <= CONV_RUN;
      else if (result_wr) st <= CONV_IDLE;
    end
  end

  // R1: a start only follows a cycle in which the chain was free
  assert_start_after_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !$past(busy));
  // R1: start pulses last one cycle
  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  // R3: busy is up together with the start
  assert_busy_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);
  // R3: without done, a running conversion keeps the chain busy
  assert_busy_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CONV_RUN && !adc_done) |=> busy);
endmodule

// File: rtl/derand_fifo.sv
module derand_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          rd_en;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign rd_en     = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: never write into a full queue
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // R6: a stalled word stays put
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/sat_acc.sv
module sat_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         snap,
  output logic [W-1:0] snap_val
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] acc;
  logic [W-1:0] nxt;

  assign nxt = (inc && acc != MAX) ? acc + 1'b1 : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      snap_val <= '0;
    end else if (snap) begin
      acc      <= '0;
      snap_val <= nxt;
    end else begin
      acc <= nxt;
    end
  end

  // R9: a saturated accumulator stays saturated until captured
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == MAX && !snap) |=> acc == MAX);
endmodule

// File: rtl/trig_busy_ctrl.sv
module trig_busy_ctrl #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              snap_req,
  output logic [CNT_W-1:0]  snap_total,
  output logic [CNT_W-1:0]  snap_busy
);
  localparam int NACC = 2;  // 0: all cycles, 1: busy cycles

  logic             q_full;
  logic             result_wr;
  logic [NACC-1:0]  acc_inc;
  logic [CNT_W-1:0] acc_snap [NACC];

  trig_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .adc_done  (adc_done),
    .hold      (q_full),
    .adc_start (adc_start),
    .busy      (busy),
    .result_wr (result_wr)
  );

  derand_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (result_wr),
    .wr_data   (adc_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .full      (q_full)
  );

  assign acc_inc = {busy, 1'b1};

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    sat_acc #(.W(CNT_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (acc_inc[g]),
      .snap     (snap_req),
      .snap_val (acc_snap[g])
    );
  end

  assign snap_total = acc_snap[0];
  assign snap_busy  = acc_snap[1];

  // R9: busy share never exceeds the whole
  assert_busy_le_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_busy <= snap_total);
  // R4: a full queue keeps the chain blocked
  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> busy);
endmodule

// File: tb/test_trig_busy_ctrl.sv
`timescale 1ns/1ps
module test_trig_busy_ctrl;
  localparam int DW = 16;
  localparam int CW = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0, adc_done = 1'b0, out_ready = 1'b0, snap_req = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic [1:0] st_w, bs_w, ov_w;
  logic [1:0][DW-1:0] od_w;
  logic [1:0][CW-1:0] sT_w, sB_w;

  always #4 clk = ~clk;

  trig_busy_ctrl #(.DATA_W(DW), .DEPTH(3), .CNT_W(CW)) i_trig_busy_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .adc_start(st_w[0]),
    .adc_done(adc_done), .adc_data(adc_data), .busy(bs_w[0]),
    .out_valid(ov_w[0]), .out_ready(out_ready), .out_data(od_w[0]),
    .snap_req(snap_req), .snap_total(sT_w[0]), .snap_busy(sB_w[0]));

  trig_busy_ctrl #(.DATA_W(DW), .DEPTH(1), .CNT_W(CW)) i_trig_busy_ctrl_d1 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .adc_start(st_w[1]),
    .adc_done(adc_done), .adc_data(adc_data), .busy(bs_w[1]),
    .out_valid(ov_w[1]), .out_ready(out_ready), .out_data(od_w[1]),
    .snap_req(snap_req), .snap_total(sT_w[1]), .snap_busy(sB_w[1]));

  int nchk = 0, nerr = 0;
  bit run = 0, done_flag = 0;

  // reference model state per instance
  int dep [2] = '{3, 1};
  bit conv [2], prevt [2], start_e [2];
  logic [DW-1:0] q [2][8];
  int qc [2];
  int mt [2], mb [2], et [2], eb [2];
  bit pv [2];
  logic [DW-1:0] pd [2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      for (int k = 0; k < 2; k++) begin
        bit busy_m, rise, acc, rd, wr;
        busy_m = conv[k] | (qc[k] == dep[k]);
        // checks on the current outputs
        chk(st_w[k] == start_e[k], "R1,R2 start", st_w[k], start_e[k]);
        chk(bs_w[k] == busy_m, "R3,R4 busy", bs_w[k], busy_m);
        chk(ov_w[k] == (qc[k] > 0), "R5 valid", ov_w[k], qc[k] > 0);
        if (qc[k] > 0) chk(od_w[k] == q[k][0], "R5,R7 data", od_w[k], q[k][0]);
        if (pv[k]) chk(ov_w[k] && od_w[k] == pd[k], "R6 stall hold", od_w[k], pd[k]);
        chk(sT_w[k] == et[k], "R8,R9 total", sT_w[k], et[k]);
        chk(sB_w[k] == eb[k], "R8,R9 busy count", sB_w[k], eb[k]);
        // next state for the coming edge
        rise = trig_in & ~prevt[k];
        acc  = rise & ~busy_m;
        rd   = out_ready && qc[k] > 0;
        wr   = conv[k] & adc_done;
        pv[k] = ov_w[k] && !out_ready;
        pd[k] = od_w[k];
        if (rd) begin
          for (int i = 0; i < 7; i++) q[k][i] = q[k][i+1];
          qc[k]--;
        end
        if (wr) begin
          q[k][qc[k]] = adc_data;
          qc[k]++;
        end
        if (acc) conv[k] = 1;
        else if (wr) conv[k] = 0;
        start_e[k] = acc;
        prevt[k] = trig_in;
        if (mt[k] < CMAX) mt[k]++;
        if (busy_m && mb[k] < CMAX) mb[k]++;
        if (snap_req) begin
          et[k] = mt[k]; eb[k] = mb[k]; mt[k] = 0; mb[k] = 0;
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(bs_w == 2'b00, "R10 busy", bs_w, 0);
    chk(st_w == 2'b00, "R10 start", st_w, 0);
    chk(ov_w == 2'b00, "R10 valid", ov_w, 0);
    chk(sT_w[0] == 0 && sB_w[0] == 0, "R10 snapshot", sT_w[0], 0);
    run = 1;
    cyc(1);
    // R3: done while idle is ignored
    adc_done = 1; adc_data = 16'h1111; cyc(1); adc_done = 0; cyc(2);
    // one accepted trigger; R2: second edge during conversion dropped
    trig_in = 1; cyc(1); trig_in = 0; cyc(2);
    trig_in = 1; cyc(1); trig_in = 0;
    // trigger edge in the same cycle as done
    cyc(2); trig_in = 1; adc_done = 1; adc_data = 16'hA5A5; cyc(1);
    adc_done = 0; trig_in = 0; cyc(3);
    out_ready = 1; cyc(2); out_ready = 0;
    snap_req = 1; cyc(1); snap_req = 0;
    // sweep trigger rate against drain rate
    for (int pt = 2; pt <= 8; pt *= 2) begin
      for (int pr = 1; pr <= 8; pr *= 2) begin
        for (int c = 0; c < 1500; c++) begin
          trig_in   = ($urandom % pt) == 0;
          adc_done  = ($urandom % 4) == 0;
          adc_data  = DW'($urandom);
          out_ready = ($urandom % pr) == 0;
          snap_req  = ($urandom % 600) == 0;
          cyc(1);
        end
      end
    end
    // R9: long window without capture saturates the 10-bit accumulators
    snap_req = 1; cyc(1); snap_req = 0;
    out_ready = 0;
    for (int c = 0; c < 1500; c++) begin
      trig_in  = ($urandom % 3) == 0;
      adc_done = ($urandom % 5) == 0;
      adc_data = DW'($urandom);
      cyc(1);
    end
    snap_req = 1; cyc(1); snap_req = 0; trig_in = 0; adc_done = 0;
    @(negedge clk);
    chk(sT_w[0] == CMAX, "R9 total saturated", sT_w[0], CMAX);
    chk(sB_w[1] == CMAX, "R9 busy saturated", sB_w[1], CMAX);
    cyc(3);
    summary();
  end
endmodule